// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when the processor core, the on-chip peripherals and the crystal oscillator get a clock. Software writes a 4-bit power-control register. One bit puts the core to sleep while the peripherals keep running (idle). Another bit stops everything, including the oscillator (power-down). The register also holds two general-purpose flag bits that the block does not interpret.

Idle ends when any enabled interrupt is pending. Power-down ends in one of two ways:
- A qualified external wake pin is pulled low. The oscillator restarts and a stabilisation counter runs. The core clock comes back only when the pin returns high after that count has expired.
- A hardware reset pin is held high long enough. The pin is filtered, and the block raises its own internal reset, which returns everything to its initial state.

The block runs on an always-on clock. It outputs clock-enable levels for the core and peripheral domains and an enable for the oscillator.

Top module: `pwr_seq`

## Requirements
- R1: After the synchronous reset `rst`, `pcon_rdata` reads 0x00, `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `int_rst` is 0.
- R2: In run mode, a write stores bit 3 (flag B) and bit 2 (flag A) of `pcon_wdata`. Bits 7:4 of `pcon_rdata` always read 0.
- R3: Writing bit 0 (idle) = 1 with bit 1 = 0 enters idle. `cpu_clk_en` drops to 0, `per_clk_en` and `osc_en` stay 1, and `pcon_rdata` bit 0 reads 1.
- R4: In idle, `irq_pend` high at a clock edge ends idle. `cpu_clk_en` is 1 after that edge, bit 0 clears, and the flags are unchanged.
- R5: Writing bit 1 (power-down) = 1 enters power-down, whatever bit 0 holds. All three enables go to 0, and `pcon_rdata` shows bit 1 set and bit 0 clear.
- R6: In power-down, none of the following leaves the mode: `irq_pend`, a low pin whose `ext_en` bit is 0, or a low pin whose `ext_edge` bit is 1 (edge mode).
- R7: In power-down, an `ext_n` pin that is low, enabled and set to level mode (`ext_edge` = 0) sets `osc_en` to 1 one edge later. `cpu_clk_en` and `per_clk_en` stay 0 for as long as the pin is held low.
- R8: The wake completes on the edge where the pin is seen high, provided `STAB_CYCLES` edges with `osc_ready` high have passed since the wake began. After that edge all enables are 1, bit 1 is clear, and the flags are kept.
- R9: If the pin returns high before the stabilisation count has expired, the block goes back to power-down. `osc_en` returns to 0 and bit 1 stays set.
- R10: `int_rst` goes to 1 only after `rst_pin` has been sampled high on `RST_CYCLES` consecutive edges while `osc_en` and `osc_ready` are both 1. It returns to 0 one edge after the pin is sampled low.
- R11: While `int_rst` is 1 the register is cleared to 0x00 and the mode returns to run. In power-down, `rst_pin` high forces `osc_en` to 1 so that the reset filter can count.
- R12: Writes made while the block is not in run mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin | input | 1 | Raw hardware reset pin, active high |
| pcon_we | input | 1 | Register write strobe |
| pcon_wdata | input | 8 | Register write data |
| pcon_rdata | output | 8 | Register read value |
| irq_pend | input | 1 | Any enabled interrupt pending |
| ext_n | input | NUM_EXT | External interrupt pins, active low |
| ext_en | input | NUM_EXT | External interrupt enables |
| ext_edge | input | NUM_EXT | 1 = edge mode, 0 = level mode |
| osc_ready | input | 1 | Oscillator running indication |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| int_rst | output | 1 | Filtered internal reset |

## Verification
The bench goes after the stabilisation boundary on its own. Releasing the wake pin at the first edge where the count has expired must resume the core. Releasing it one edge earlier must drop back to power-down. An off-by-one counter would either wake on an unstable oscillator or trap the part in power-down.

It also places reset-pin pulses one cycle short of the filter length, and pulses while the oscillator is not ready. A filter that counts wrongly would reset the chip on glitches.

It checks that edge-mode and disabled pins cannot wake the part, and that writing both mode bits picks power-down. It also checks that writes during idle or power-down are lost, since a design that honoured them would corrupt the register while the core is asleep.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int REG_W    = 8;
    localparam int CTL_W    = 4;
    localparam int IDLE_POS = 0;
    localparam int DOWN_POS = 1;
    localparam int FLGA_POS = 2;
    localparam int FLGB_POS = 3;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2,
        PM_WAKE = 2'd3
    } pmode_e;

    // Field order matches bit positions 3..0 of the register.
    typedef struct packed {
        logic flg_b;
        logic flg_a;
        logic down;
        logic idle;
    } pctl_t;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
    } gates_t;

    function automatic gates_t mode_gates(pmode_e m);
        gates_t g;
        case (m)
            PM_RUN:  g = '{cpu: 1'b1, per: 1'b1, osc: 1'b1};
            PM_IDLE: g = '{cpu: 1'b0, per: 1'b1, osc: 1'b1};
            PM_WAKE: g = '{cpu: 1'b0, per: 1'b0, osc: 1'b1};
            default: g = '{cpu: 1'b0, per: 1'b0, osc: 1'b0};
        endcase
        return g;
    endfunction

    function automatic logic [REG_W-1:0] pctl_read(pctl_t p);
        return {{(REG_W-CTL_W){1'b0}}, p};
    endfunction

endpackage

// File: rtl/pwr_rst_filter.sv
module pwr_rst_filter #(
    parameter int RST_CYCLES = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic osc_run,
    output logic int_rst
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            hold_q <= 1'b0;
        end else if (!pin) begin
            cnt    <= '0;
            hold_q <= 1'b0;
        end else if (!osc_run) begin
            cnt    <= '0;
        end else begin
            if (cnt != LAST) cnt <= cnt + 1'b1;
            if (cnt == LAST) hold_q <= 1'b1;
        end
    end

    assign int_rst = hold_q;
endmodule

// File: rtl/pwr_stab_timer.sv
module pwr_stab_timer #(
    parameter int STAB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(STAB_CYCLES + 1);
    localparam logic [CW-1:0] FULL = CW'(STAB_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick && cnt != FULL)
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == FULL);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             irq_pend,
    input  logic             wake_low,
    input  logic             stab_done,
    output pmode_e           mode,
    output pctl_t            ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= PM_RUN;
            ctl  <= '0;
        end else begin
            case (mode)
                PM_RUN: if (we) begin
                    ctl.flg_b <= wdata[FLGB_POS];
                    ctl.flg_a <= wdata[FLGA_POS];
                    if (wdata[DOWN_POS]) begin
                        ctl.down <= 1'b1;
                        ctl.idle <= 1'b0;
                        mode     <= PM_DOWN;
                    end else if (wdata[IDLE_POS]) begin
                        ctl.idle <= 1'b1;
                        mode     <= PM_IDLE;
                    end
                end
                PM_IDLE: if (irq_pend) begin
                    ctl.idle <= 1'b0;
                    mode     <= PM_RUN;
                end
                PM_DOWN: if (wake_low) mode <= PM_WAKE;
                PM_WAKE: if (!wake_low) begin
                    if (stab_done) begin
                        ctl.down <= 1'b0;
                        mode     <= PM_RUN;
                    end else begin
                        mode     <= PM_DOWN;
                    end
                end
                default: mode <= PM_RUN;
            endcase
        end
    end
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int NUM_EXT     = 2,
    parameter int RST_CYCLES  = 24,
    parameter int STAB_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rst_pin,
    input  logic               pcon_we,
    input  logic [REG_W-1:0]   pcon_wdata,
    output logic [REG_W-1:0]   pcon_rdata,
    input  logic               irq_pend,
    input  logic [NUM_EXT-1:0] ext_n,
    input  logic [NUM_EXT-1:0] ext_en,
    input  logic [NUM_EXT-1:0] ext_edge,
    input  logic               osc_ready,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               osc_en,
    output logic               int_rst
);
    logic [NUM_EXT-1:0] wake_vec;
    logic               wake_low;
    logic               stab_done;
    logic               fsm_rst;
    pmode_e             mode;
    pctl_t              ctl;
    gates_t             gates;

    // Only enabled, level-configured pins may wake from power-down.
    for (genvar i = 0; i < NUM_EXT; i++) begin : g_wake
        assign wake_vec[i] = ext_en[i] & ~ext_edge[i] & ~ext_n[i];
    end
    assign wake_low = |wake_vec;

    assign gates   = mode_gates(mode);
    assign fsm_rst = rst | int_rst;

    pwr_rst_filter #(.RST_CYCLES(RST_CYCLES)) u_filter (
        .clk     (clk),
        .rst     (rst),
        .pin     (rst_pin),
        .osc_run (osc_en & osc_ready),
        .int_rst (int_rst)
    );

    pwr_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
        .clk  (clk),
        .rst  (fsm_rst),
        .clr  (mode != PM_WAKE),
        .tick (osc_ready),
        .done (stab_done)
    );

    pwr_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (fsm_rst),
        .we        (pcon_we),
        .wdata     (pcon_wdata),
        .irq_pend  (irq_pend),
        .wake_low  (wake_low),
        .stab_done (stab_done),
        .mode      (mode),
        .ctl       (ctl)
    );

    assign pcon_rdata = pctl_read(ctl);
    assign cpu_clk_en = gates.cpu;
    assign per_clk_en = gates.per;
    assign osc_en     = gates.osc | rst_pin;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       rst_pin,
    input logic       irq_pend,
    input logic [7:0] pcon_rdata,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       int_rst
);
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        pcon_rdata[7:4] == 4'h0);                                              // R2
    AST_IDLE_GATES: assert property (@(posedge clk) disable iff (rst)
        pcon_rdata[0] |-> (!cpu_clk_en && per_clk_en));                        // R3
    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (rst)
        (pcon_rdata[0] && irq_pend) |=> (cpu_clk_en && !pcon_rdata[0]));       // R4
    AST_MODE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pcon_rdata[0] && pcon_rdata[1]));                                    // R5
    AST_DOWN_CPU_OFF: assert property (@(posedge clk) disable iff (rst)
        (pcon_rdata[1] && !int_rst) |-> !cpu_clk_en);                          // R5
    AST_RESUME_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> (pcon_rdata[1:0] == 2'b00));                     // R8
    AST_RST_NEEDS_PIN: assert property (@(posedge clk) disable iff (rst)
        $rose(int_rst) |-> $past(rst_pin));                                    // R10
    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        int_rst |=> (pcon_rdata == 8'h00));                                    // R11
endmodule

bind pwr_seq pwr_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rst_pin    (rst_pin),
    .irq_pend   (irq_pend),
    .pcon_rdata (pcon_rdata),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .int_rst    (int_rst)
);

// File: tb/pwr_seq_bench.sv
module pwr_seq_bench;
    localparam int STAB = 16;
    localparam int RSTN = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_pin = 1'b0;
    logic       pcon_we = 1'b0;
    logic [7:0] pcon_wdata = '0;
    logic [7:0] pcon_rdata;
    logic       irq_pend = 1'b0;
    logic [1:0] ext_n = 2'b11;
    logic [1:0] ext_en = 2'b00;
    logic [1:0] ext_edge = 2'b00;
    logic       osc_ready = 1'b1;
    logic       cpu_clk_en, per_clk_en, osc_en, int_rst;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pwr_seq #(.NUM_EXT(2), .RST_CYCLES(RSTN), .STAB_CYCLES(STAB)) u_pwr_seq (
        .clk(clk), .rst(rst), .rst_pin(rst_pin), .pcon_we(pcon_we),
        .pcon_wdata(pcon_wdata), .pcon_rdata(pcon_rdata), .irq_pend(irq_pend),
        .ext_n(ext_n), .ext_en(ext_en), .ext_edge(ext_edge), .osc_ready(osc_ready),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .int_rst(int_rst)
    );

    // {wdata, expected read, expected cpu/per/osc}
    localparam logic [18:0] VEC [7] = '{
        {8'h0C, 8'h0C, 3'b111},   // R2
        {8'hF4, 8'h04, 3'b111},   // R2
        {8'h01, 8'h01, 3'b011},   // R3
        {8'h09, 8'h09, 3'b011},   // R3
        {8'h02, 8'h02, 3'b000},   // R5
        {8'h03, 8'h02, 3'b000},   // R5 both set: power-down wins
        {8'h0E, 8'h0E, 3'b000}    // R5
    };

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gts();
        return {5'b0, cpu_clk_en, per_clk_en, osc_en};
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        pcon_we = 1'b0; irq_pend = 1'b0; rst_pin = 1'b0;
        ext_n = 2'b11; ext_en = 2'b00; ext_edge = 2'b00; osc_ready = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic wr(logic [7:0] d);
        pcon_we = 1'b1; pcon_wdata = d;
        tick(1);
        pcon_we = 1'b0;
    endtask

    initial begin
        #4ms;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 read", pcon_rdata, 8'h00);
        chk("R1 gates", gts(), 8'h07);
        chk("R1 int_rst", {7'b0, int_rst}, 8'h00);

        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][18:11]);
            chk("R2/R3/R5 table read", pcon_rdata, VEC[i][10:3]);
            chk("R2/R3/R5 table gates", gts(), {5'b0, VEC[i][2:0]});
            do_reset();
        end

        // R4 idle exit, R12 write in idle ignored
        wr(8'h05);
        wr(8'h0A);
        chk("R12 idle write ignored", pcon_rdata, 8'h05);
        irq_pend = 1'b1; tick(1); irq_pend = 1'b0;
        chk("R4 idle exit read", pcon_rdata, 8'h04);
        chk("R4 idle exit gates", gts(), 8'h07);

        // R6 ignored wake sources
        wr(8'h0A);
        ext_en = 2'b11; ext_edge = 2'b11; ext_n = 2'b00; tick(4);
        chk("R6 edge-mode pin", gts(), 8'h00);
        ext_en = 2'b00; ext_edge = 2'b00; tick(4);
        chk("R6 disabled pin", gts(), 8'h00);
        ext_n = 2'b11; irq_pend = 1'b1; tick(4); irq_pend = 1'b0;
        chk("R6 irq in power-down", gts(), 8'h00);
        wr(8'h00);
        chk("R12 power-down write ignored", pcon_rdata, 8'h0A);

        // R7/R8 exact boundary: low for STAB+1 edges, then release
        ext_en = 2'b10; ext_n = 2'b01;
        tick(1);
        chk("R7 oscillator restarts", gts(), 8'h01);
        tick(STAB);
        chk("R7 held low keeps core off", gts(), 8'h01);
        ext_n = 2'b11; tick(1);
        chk("R8 wake completes gates", gts(), 8'h07);
        chk("R8 wake keeps flags", pcon_rdata, 8'h08);

        // R9 release one edge early
        wr(8'h02);
        ext_n = 2'b01; tick(STAB);
        ext_n = 2'b11; tick(1);
        chk("R9 early release gates", gts(), 8'h00);
        chk("R9 early release read", pcon_rdata, 8'h02);
        ext_n = 2'b01; tick(3); ext_n = 2'b11; tick(1);
        chk("R9 short pulse gates", gts(), 8'h00);
        ext_en = 2'b00;
        do_reset();

        // R10 filter length
        wr(8'h0C);
        rst_pin = 1'b1; tick(RSTN - 1); rst_pin = 1'b0; tick(1);
        chk("R10 short pulse no reset", {7'b0, int_rst}, 8'h00);
        chk("R10 short pulse keeps reg", pcon_rdata, 8'h0C);
        osc_ready = 1'b0; rst_pin = 1'b1; tick(RSTN + 6);
        chk("R10 oscillator not ready", {7'b0, int_rst}, 8'h00);
        osc_ready = 1'b1; tick(RSTN);
        chk("R10 full pulse resets", {7'b0, int_rst}, 8'h01);
        tick(1);
        chk("R11 reset clears reg", pcon_rdata, 8'h00);
        rst_pin = 1'b0; tick(1);
        chk("R10 release", {7'b0, int_rst}, 8'h00);

        // R11 reset out of power-down
        wr(8'h06);
        #1 rst_pin = 1'b1; #1;
        chk("R11 pin forces oscillator", {7'b0, osc_en}, 8'h01);
        @(negedge clk);
        tick(RSTN);
        tick(1);
        chk("R11 power-down reset read", pcon_rdata, 8'h00);
        chk("R11 power-down reset gates", gts(), 8'h07);
        rst_pin = 1'b0; tick(2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule